// File: doc/BRIEF.md
# Synchronous Dual-Port RAM with Per-Port Read Latency

A storage array reached through two fully independent ports, A and B, each running on its own clock. On every rising edge of its clock a port captures its address, write data, both chip-select inputs and its write strobe. A selected port either stores its write data or fetches a word. The fetched word leaves the port after a latency set by a static latency pin on that port: one edge (flow-through) or two edges (pipelined).

The outputs are modelled as a data bus plus a drive flag that stands for a tri-state bus. Whether the bus is driven depends on the controls captured at the previous edge. An asynchronous, active-low output enable can always silence it. Either port can reach any word at any time. A write becomes visible to the other port from the next edge after the one that stored it. A read on one port that coincides with a write to the same word on the other port returns the previous contents. When both ports write one word at the same edge, port A's data is kept.

Top module: `twin_ram`

## Requirements
- R1: A port is selected only when its low-active select input (`*_sel_lo_n`) is 0 and its high-active select input (`*_sel_hi`) is 1. A deselected port stores nothing, and after that edge its drive flag is low.
- R2: At a rising edge a selected port with `*_wr_n` = 0 stores `*_wdata` at `*_addr`. With `*_wr_n` = 1 it reads the word at `*_addr`.
- R3: `*_oe_n` acts without a clock. While it is 1 the drive flag is 0, even after a selected read. When it falls to 0, the pending read word appears with no clock edge.
- R4: While the drive flag is 0, the data output is all zeros. This holds during reset as well.
- R5: With `*_lat_pipe` = 0 (flow-through), a read captured at an edge drives its word from that edge until the next edge.
- R6: With `*_lat_pipe` = 1 (pipelined), a read captured at edge k is not driven after edge k. It is driven, with its word, from edge k+1 until edge k+2.
- R7: The drive flag follows the controls captured at the previous edge. In flow-through mode, a write or a deselect captured at an edge leaves the output undriven after that edge.
- R8: A word written through one port is returned by a read that the other port captures at any later edge. This holds whichever port wrote last.
- R9: When one port reads a word at the same edge as the other port writes that word, the read returns the old contents. The next read returns the new value.
- R10: When both ports write the same word at the same edge, port A's data is stored.
- R11: While `rst_n` is 0, both drive flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| b_clk | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset of the output state |
| a_sel_lo_n | input | 1 | Port A select, active low |
| a_sel_hi | input | 1 | Port A select, active high |
| a_wr_n | input | 1 | Port A: 0 write, 1 read |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_lat_pipe | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when undriven |
| a_drive | output | 1 | Port A bus-driven flag |
| b_sel_lo_n | input | 1 | Port B select, active low |
| b_sel_hi | input | 1 | Port B select, active high |
| b_wr_n | input | 1 | Port B: 0 write, 1 read |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_lat_pipe | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when undriven |
| b_drive | output | 1 | Port B bus-driven flag |

## Verification
The hardest situations to reach are those in which both ports act on one word at the very same edge: a cross-port read during a write, and two writes that collide. Both need the two clocks aligned, so the bench drives both ports from one 100 MHz clock. It sets the inputs of A and B in the same half-cycle, which puts the colliding operations at one edge. The bench then reads the word back through both ports at a later edge to show which value survived. A second hard case is a word rewritten alternately by both ports. The bench covers it with a write/write/read/write/read sequence across the two ports, so the newest-writer tracking is exercised in both directions.

// File: rtl/twin_ram_pkg.sv
package twin_ram_pkg;

    typedef enum logic {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } lat_mode_e;

    function automatic logic port_selected(input logic lo_n, input logic hi);
        return (!lo_n) && hi;
    endfunction

endpackage

// File: rtl/twin_ram_port.sv
module twin_ram_port
    import twin_ram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic              wr_n,
    input  logic              oe_n,
    input  logic              lat_sel,
    input  logic [DATA_W-1:0] lookup_word,
    output logic              wr_strobe,
    output logic [DATA_W-1:0] rdata,
    output logic              drive
);

    typedef struct packed {
        logic              stage1_vld;
        logic              stage2_vld;
        logic [DATA_W-1:0] stage1_word;
        logic [DATA_W-1:0] stage2_word;
    } port_st_t;

    port_st_t st_d, st_q;
    logic     rd_now;
    logic     stage_vld;
    logic [DATA_W-1:0] stage_word;

    always_comb begin
        rd_now    = port_selected(sel_lo_n, sel_hi) && wr_n;
        wr_strobe = port_selected(sel_lo_n, sel_hi) && !wr_n;

        st_d             = st_q;
        st_d.stage1_vld  = rd_now;
        st_d.stage2_vld  = st_q.stage1_vld;
        if (rd_now) begin
            st_d.stage1_word = lookup_word;
        end
        if (st_q.stage1_vld) begin
            st_d.stage2_word = st_q.stage1_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (lat_mode_e'(lat_sel) == LAT_PIPE) begin
            stage_vld  = st_q.stage2_vld;
            stage_word = st_q.stage2_word;
        end else begin
            stage_vld  = st_q.stage1_vld;
            stage_word = st_q.stage1_word;
        end
        drive = stage_vld && !oe_n;
        rdata = drive ? stage_word : '0;
    end

endmodule

// File: rtl/twin_ram_bank.sv
module twin_ram_bank #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 9,
    parameter bit FOLLOW_PEER = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [(1<<ADDR_W)-1:0]  peer_tog,
    input  logic [ADDR_W-1:0]       raddr0,
    input  logic [ADDR_W-1:0]       raddr1,
    output logic [DATA_W-1:0]       rword0,
    output logic [DATA_W-1:0]       rword1,
    output logic [(1<<ADDR_W)-1:0]  tog
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0]  tog_d, tog_q;
    logic              new_tag;

    generate
        if (FOLLOW_PEER) begin : g_follow
            always_comb new_tag = peer_tog[waddr];
        end else begin : g_differ
            always_comb new_tag = !peer_tog[waddr];
        end
    endgenerate

    always_comb begin
        tog_d = tog_q;
        if (we) begin
            tog_d[waddr] = new_tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q <= '0;
        end else begin
            tog_q <= tog_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rword0 = mem_q[raddr0];
    assign rword1 = mem_q[raddr1];
    assign tog    = tog_q;

endmodule

// File: rtl/twin_ram.sv
module twin_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              a_clk,
    input  logic              b_clk,
    input  logic              rst_n,
    input  logic              a_sel_lo_n,
    input  logic              a_sel_hi,
    input  logic              a_wr_n,
    input  logic              a_oe_n,
    input  logic              a_lat_pipe,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_drive,
    input  logic              b_sel_lo_n,
    input  logic              b_sel_hi,
    input  logic              b_wr_n,
    input  logic              b_oe_n,
    input  logic              b_lat_pipe,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_drive
);

    localparam int DEPTH = 1 << ADDR_W;

    logic              a_wr_strobe, b_wr_strobe, b_we_eff;
    logic [DEPTH-1:0]  tog_a, tog_b;
    logic [DATA_W-1:0] bank_a_at_a, bank_a_at_b, bank_b_at_a, bank_b_at_b;
    logic [DATA_W-1:0] a_lookup, b_lookup;

    // Port A wins a same-edge write collision: B's store is dropped.
    always_comb begin
        b_we_eff = b_wr_strobe && !(a_wr_strobe && (a_addr == b_addr));
    end

    // Equal tags mark bank B as newest, unequal tags mark bank A.
    always_comb begin
        a_lookup = (tog_a[a_addr] == tog_b[a_addr]) ? bank_b_at_a : bank_a_at_a;
        b_lookup = (tog_a[b_addr] == tog_b[b_addr]) ? bank_b_at_b : bank_a_at_b;
    end

    twin_ram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FOLLOW_PEER(1'b0)) i_bank_a (
        .clk      (a_clk),
        .rst_n    (rst_n),
        .we       (a_wr_strobe),
        .waddr    (a_addr),
        .wdata    (a_wdata),
        .peer_tog (tog_b),
        .raddr0   (a_addr),
        .raddr1   (b_addr),
        .rword0   (bank_a_at_a),
        .rword1   (bank_a_at_b),
        .tog      (tog_a)
    );

    twin_ram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FOLLOW_PEER(1'b1)) i_bank_b (
        .clk      (b_clk),
        .rst_n    (rst_n),
        .we       (b_we_eff),
        .waddr    (b_addr),
        .wdata    (b_wdata),
        .peer_tog (tog_a),
        .raddr0   (a_addr),
        .raddr1   (b_addr),
        .rword0   (bank_b_at_a),
        .rword1   (bank_b_at_b),
        .tog      (tog_b)
    );

    twin_ram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port_a (
        .clk         (a_clk),
        .rst_n       (rst_n),
        .sel_lo_n    (a_sel_lo_n),
        .sel_hi      (a_sel_hi),
        .wr_n        (a_wr_n),
        .oe_n        (a_oe_n),
        .lat_sel     (a_lat_pipe),
        .lookup_word (a_lookup),
        .wr_strobe   (a_wr_strobe),
        .rdata       (a_rdata),
        .drive       (a_drive)
    );

    twin_ram_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port_b (
        .clk         (b_clk),
        .rst_n       (rst_n),
        .sel_lo_n    (b_sel_lo_n),
        .sel_hi      (b_sel_hi),
        .wr_n        (b_wr_n),
        .oe_n        (b_oe_n),
        .lat_sel     (b_lat_pipe),
        .lookup_word (b_lookup),
        .wr_strobe   (b_wr_strobe),
        .rdata       (b_rdata),
        .drive       (b_drive)
    );

endmodule

// File: rtl/twin_ram_chk.sv
module twin_ram_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input logic              a_clk,
    input logic              b_clk,
    input logic              rst_n,
    input logic              a_sel_lo_n,
    input logic              a_sel_hi,
    input logic              a_wr_n,
    input logic              a_oe_n,
    input logic              a_lat_pipe,
    input logic [DATA_W-1:0] a_rdata,
    input logic              a_drive,
    input logic              b_oe_n,
    input logic [DATA_W-1:0] b_rdata,
    input logic              b_drive
);

    logic [1:0] a_up_q;
    logic       a_rd_in;

    assign a_rd_in = !a_sel_lo_n && a_sel_hi && a_wr_n;

    always_ff @(posedge a_clk or negedge rst_n) begin
        if (!rst_n) begin
            a_up_q <= '0;
        end else if (a_up_q != 2'd3) begin
            a_up_q <= a_up_q + 2'd1;
        end
    end

    // R3
    p_oe_silences_r3: assert property (@(posedge a_clk) disable iff (!rst_n)
        a_oe_n |-> !a_drive);
    p_oe_silences_b_r3: assert property (@(posedge b_clk) disable iff (!rst_n)
        b_oe_n |-> !b_drive);
    // R4
    p_idle_zero_r4: assert property (@(posedge a_clk) disable iff (!rst_n)
        !a_drive |-> (a_rdata == '0));
    p_idle_zero_b_r4: assert property (@(posedge b_clk) disable iff (!rst_n)
        !b_drive |-> (b_rdata == '0));
    // R5
    p_flow_drive_r5: assert property (@(posedge a_clk) disable iff (!rst_n)
        (!a_lat_pipe && !a_oe_n && (a_up_q >= 2'd1) && $past(a_rd_in)) |-> a_drive);
    // R7
    p_flow_quiet_r7: assert property (@(posedge a_clk) disable iff (!rst_n)
        (!a_lat_pipe && (a_up_q >= 2'd1) && !$past(a_rd_in)) |-> !a_drive);
    // R6
    p_pipe_drive_r6: assert property (@(posedge a_clk) disable iff (!rst_n)
        (a_lat_pipe && !a_oe_n && (a_up_q >= 2'd2) && $past(a_rd_in, 2)) |-> a_drive);

endmodule

bind twin_ram twin_ram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_twin_ram_chk (
    .a_clk      (a_clk),
    .b_clk      (b_clk),
    .rst_n      (rst_n),
    .a_sel_lo_n (a_sel_lo_n),
    .a_sel_hi   (a_sel_hi),
    .a_wr_n     (a_wr_n),
    .a_oe_n     (a_oe_n),
    .a_lat_pipe (a_lat_pipe),
    .a_rdata    (a_rdata),
    .a_drive    (a_drive),
    .b_oe_n     (b_oe_n),
    .b_rdata    (b_rdata),
    .b_drive    (b_drive)
);

// File: tb/test_twin_ram.sv
module test_twin_ram;

    localparam int AW = 8;
    localparam int DW = 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          a_sel_lo_n, a_sel_hi, a_wr_n, a_oe_n, a_lat_pipe;
    logic [AW-1:0] a_addr;
    logic [DW-1:0] a_wdata, a_rdata;
    logic          a_drive;
    logic          b_sel_lo_n, b_sel_hi, b_wr_n, b_oe_n, b_lat_pipe;
    logic [AW-1:0] b_addr;
    logic [DW-1:0] b_wdata, b_rdata;
    logic          b_drive;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    twin_ram #(.ADDR_W(AW), .DATA_W(DW)) i_twin_ram (
        .a_clk(clk), .b_clk(clk), .rst_n(rst_n),
        .a_sel_lo_n(a_sel_lo_n), .a_sel_hi(a_sel_hi), .a_wr_n(a_wr_n),
        .a_oe_n(a_oe_n), .a_lat_pipe(a_lat_pipe), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drive(a_drive),
        .b_sel_lo_n(b_sel_lo_n), .b_sel_hi(b_sel_hi), .b_wr_n(b_wr_n),
        .b_oe_n(b_oe_n), .b_lat_pipe(b_lat_pipe), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drive(b_drive)
    );

    typedef struct packed {
        logic          lo_n;
        logic          hi;
        logic          wr_n;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic          exp_drv;
        logic [DW-1:0] exp_data;
    } vec_t;

    // Port A, flow-through, output enabled; expectations after the edge.
    localparam vec_t VEC [0:8] = '{
        '{1'b0, 1'b1, 1'b0, 8'h05, 9'h1AA, 1'b0, 9'h000},
        '{1'b0, 1'b1, 1'b0, 8'h06, 9'h055, 1'b0, 9'h000},
        '{1'b0, 1'b1, 1'b1, 8'h05, 9'h000, 1'b1, 9'h1AA},
        '{1'b0, 1'b1, 1'b1, 8'h06, 9'h000, 1'b1, 9'h055},
        '{1'b1, 1'b1, 1'b0, 8'h05, 9'h0FF, 1'b0, 9'h000},
        '{1'b0, 1'b1, 1'b1, 8'h05, 9'h000, 1'b1, 9'h1AA},
        '{1'b0, 1'b0, 1'b1, 8'h06, 9'h000, 1'b0, 9'h000},
        '{1'b0, 1'b1, 1'b0, 8'h06, 9'h123, 1'b0, 9'h000},
        '{1'b0, 1'b1, 1'b1, 8'h06, 9'h000, 1'b1, 9'h123}
    };

    task automatic chk(input string tag, input logic [DW:0] got, input logic [DW:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic set_a(input logic lo_n, input logic hi, input logic wr_n,
                         input logic [AW-1:0] addr, input logic [DW-1:0] d);
        a_sel_lo_n = lo_n; a_sel_hi = hi; a_wr_n = wr_n; a_addr = addr; a_wdata = d;
    endtask

    task automatic set_b(input logic lo_n, input logic hi, input logic wr_n,
                         input logic [AW-1:0] addr, input logic [DW-1:0] d);
        b_sel_lo_n = lo_n; b_sel_hi = hi; b_wr_n = wr_n; b_addr = addr; b_wdata = d;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(100000 * 10);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        a_oe_n = 1'b0; b_oe_n = 1'b0; a_lat_pipe = 1'b0; b_lat_pipe = 1'b0;
        set_a(1'b0, 1'b1, 1'b1, 8'h00, 9'h000);
        set_b(1'b0, 1'b1, 1'b1, 8'h00, 9'h000);
        repeat (3) @(negedge clk);
        // R11 / R4: reset holds outputs undriven even with reads requested
        chk("R11 a_drive in reset", {8'h00, a_drive}, 10'h000);
        chk("R11 b_drive in reset", {8'h00, b_drive}, 10'h000);
        chk("R4 a_rdata in reset", {1'b0, a_rdata}, 10'h000);
        set_a(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        set_b(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        rst_n = 1'b1;
        tick();

        // R1 R2 R5 R7 table walk on port A
        for (int i = 0; i < 9; i++) begin
            set_a(VEC[i].lo_n, VEC[i].hi, VEC[i].wr_n, VEC[i].addr, VEC[i].wdata);
            tick();
            chk($sformatf("R2/R5/R1/R7 vec%0d", i), {a_drive, a_rdata},
                {VEC[i].exp_drv, VEC[i].exp_data});
        end

        // R3: output enable high silences a read; dropping it shows the word without a clock
        a_oe_n = 1'b1;
        set_a(1'b0, 1'b1, 1'b1, 8'h05, 9'h000);
        tick();
        chk("R3 oe_n high silences", {a_drive, a_rdata}, 10'h000);
        a_oe_n = 1'b0;
        #1;
        chk("R3 oe_n low drives async", {a_drive, a_rdata}, {1'b1, 9'h1AA});

        // R6: pipelined latency
        set_a(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        a_lat_pipe = 1'b1;
        tick();
        tick();
        set_a(1'b0, 1'b1, 1'b1, 8'h05, 9'h000);
        tick();
        chk("R6 pipe not yet driven", {a_drive, a_rdata}, 10'h000);
        set_a(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        tick();
        chk("R6 pipe word after second edge", {a_drive, a_rdata}, {1'b1, 9'h1AA});
        tick();
        chk("R6 pipe released", {a_drive, a_rdata}, 10'h000);
        a_lat_pipe = 1'b0;

        // R8: B writes, A reads later
        set_b(1'b0, 1'b1, 1'b0, 8'h10, 9'h0AB);
        tick();
        set_b(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        set_a(1'b0, 1'b1, 1'b1, 8'h10, 9'h000);
        tick();
        chk("R8 A sees B write", {a_drive, a_rdata}, {1'b1, 9'h0AB});

        // R9: A writes while B reads the same word at the same edge
        set_a(1'b0, 1'b1, 1'b0, 8'h10, 9'h111);
        set_b(1'b0, 1'b1, 1'b1, 8'h10, 9'h000);
        tick();
        chk("R9 B reads old word", {b_drive, b_rdata}, {1'b1, 9'h0AB});
        set_a(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        tick();
        chk("R9 B reads new word next", {b_drive, b_rdata}, {1'b1, 9'h111});

        // R10: both write the same word at one edge
        set_a(1'b0, 1'b1, 1'b0, 8'h20, 9'h1C3);
        set_b(1'b0, 1'b1, 1'b0, 8'h20, 9'h03C);
        tick();
        set_a(1'b0, 1'b1, 1'b1, 8'h20, 9'h000);
        set_b(1'b0, 1'b1, 1'b1, 8'h20, 9'h000);
        tick();
        chk("R10 A keeps A data", {a_drive, a_rdata}, {1'b1, 9'h1C3});
        chk("R10 B sees A data", {b_drive, b_rdata}, {1'b1, 9'h1C3});

        // R8: alternating writers on one word
        set_a(1'b0, 1'b1, 1'b0, 8'h30, 9'h001);
        set_b(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        tick();
        set_a(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        set_b(1'b0, 1'b1, 1'b0, 8'h30, 9'h002);
        tick();
        set_b(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        set_a(1'b0, 1'b1, 1'b1, 8'h30, 9'h000);
        tick();
        chk("R8 A sees later B write", {a_drive, a_rdata}, {1'b1, 9'h002});
        set_a(1'b0, 1'b1, 1'b0, 8'h30, 9'h0F0);
        tick();
        set_a(1'b1, 1'b1, 1'b1, 8'h00, 9'h000);
        set_b(1'b0, 1'b1, 1'b1, 8'h30, 9'h000);
        tick();
        chk("R8 B sees later A write", {b_drive, b_rdata}, {1'b1, 9'h0F0});

        // R2 / R1 on port B: own write, ignored deselected write
        set_b(1'b0, 1'b1, 1'b0, 8'h40, 9'h155);
        tick();
        chk("R7 B write leaves bus undriven", {b_drive, b_rdata}, 10'h000);
        set_b(1'b0, 1'b0, 1'b0, 8'h40, 9'h000);
        tick();
        set_b(1'b0, 1'b1, 1'b1, 8'h40, 9'h000);
        tick();
        chk("R1 R2 B keeps own write", {b_drive, b_rdata}, {1'b1, 9'h155});

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule